// File: doc/BRIEF.md
# Variable-Size Byte Pointer Sequencer

This block moves a stream of bytes between a byte-wide valid/ready interface and a 36-bit word memory. A byte is 16, 12, 8, 7 or 6 bits wide. Each transfer starts from a pointer made of a size code, a word address and a word count. In every word the bytes are packed from the most significant end. The low-order bits that are left over at the end of a word are never used.

In a read transfer the block fetches each word and hands its bytes out one at a time. In a write transfer it collects bytes into a word and stores that word once it is full, or earlier when the writer marks its last byte. After every word the address moves up by one and the count drops by one. When the count reaches zero the block stops and raises a word-count overflow flag. A size code that has no byte size behind it raises an error flag and moves no data.

Top module: `bps_seq`

## Requirements
- R1: Size code 2 gives 16-bit bytes and 2 per word. Code 3 gives 12-bit bytes and 3 per word. Code 4 gives 8-bit bytes and 4 per word. Code 5 gives 7-bit bytes and 5 per word. Code 6 gives 6-bit bytes and 6 per word.
- R2: In a read, byte k of a word (k counted from 0) is bits [35-s*k : 36-s*(k+1)] of that word, where s is the byte size. It appears right-aligned on `rd_data` with the upper bits zero. Leftover low-order bits are never output.
- R3: Words are read or written at `base_addr`, then `base_addr`+1, and so on, one memory access per word.
- R4: Each completed word reduces the count by one. When the count reaches zero, `busy` falls and `wc_ovf` is set in the same cycle, and no further access follows. A start with a count of zero sets `wc_ovf` at once and makes no access.
- R5: Size codes 0, 1 and 7 set `size_err`, leave `busy` low and cause no memory access and no stream activity.
- R6: In a write (`dir`=1), byte k of a word is placed left-justified in the same position R2 gives for a read. Only the low s bits of `wr_data` are used. A full word is written in one access.
- R7: A byte taken with `wr_last`=1 ends the transfer. A partly filled word is written with its unfilled bits zero, and `wc_ovf` stays clear unless the count reached zero.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` does not change.
- R9: After reset, `busy`, `wc_ovf`, `size_err`, `mem_req`, `rd_valid` and `wr_ready` are all low.
- R10: A `start` that arrives while `busy` is high is ignored, and the running transfer goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer; taken only while idle |
| dir | input | 1 | 0 = read memory into the byte stream, 1 = write the byte stream into memory |
| size_code | input | 3 | Byte size code |
| word_count | input | CNT_W | Number of words to transfer |
| base_addr | input | ADDR_W | First word address |
| busy | output | 1 | Transfer in progress |
| wc_ovf | output | 1 | Word count ran out; cleared by the next accepted start |
| size_err | output | 1 | Illegal size code at the last start |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 16 | Read byte, right-aligned |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block takes the write byte |
| wr_data | input | 16 | Write byte; only the low s bits are used |
| wr_last | input | 1 | Marks the final write byte |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 36 | Word to store |
| mem_rdata | input | 36 | Read word, due one cycle after the request |

## Verification
After an accepted `start`, the block raises `mem_req` in the next cycle. The read word arrives one cycle after the request and is loaded at the following edge, so the first `rd_valid` comes three cycles after `start`. Every byte handshake takes effect at a clock edge. Flags and `busy` change at the edge that completes the last word. The bench drives its inputs and samples all outputs at the falling edge. It counts a byte as taken only when `rd_valid`/`wr_ready` and its own ready/valid were both high in the half-cycle before the rising edge, so every check compares against the value registered at that edge. Memory contents and the logged addresses are checked only after `busy` has been seen low.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int WORD_W = 36;
  localparam int MAXB_W = 16;
  localparam int SZ_W   = 5;
  localparam int POS_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RREQ, ST_RWAIT, ST_RSTREAM, ST_WFILL, ST_WWRITE
  } bps_state_e;

  typedef struct packed {
    logic             legal;
    logic [SZ_W-1:0]  bits;
    logic [POS_W-1:0] per_word;
  } bps_fmt_t;

  function automatic bps_fmt_t fmt_of(input logic [2:0] code);
    bps_fmt_t f;
    f = '0;
    case (code)
      3'd2: begin f.legal = 1'b1; f.bits = 5'd16; f.per_word = 3'd2; end
      3'd3: begin f.legal = 1'b1; f.bits = 5'd12; f.per_word = 3'd3; end
      3'd4: begin f.legal = 1'b1; f.bits = 5'd8;  f.per_word = 3'd4; end
      3'd5: begin f.legal = 1'b1; f.bits = 5'd7;  f.per_word = 3'd5; end
      3'd6: begin f.legal = 1'b1; f.bits = 5'd6;  f.per_word = 3'd6; end
      default: f = '0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/bps_size_decode.sv
module bps_size_decode
  import bps_pkg::*;
(
  input  logic [2:0] code,
  output bps_fmt_t   fmt
);
  always_comb begin
    fmt = fmt_of(code);
    // R1: the bytes of a legal size fill a word with fewer than s bits left over
    if (fmt.legal) begin
      a_r1_fit: assert ((int'(fmt.per_word) * int'(fmt.bits) <= WORD_W) &&
                        (int'(fmt.per_word) * int'(fmt.bits) + int'(fmt.bits) > WORD_W))
        else $error("a_r1_fit: size table inconsistent");
    end
  end
endmodule

// File: rtl/bps_unpack.sv
module bps_unpack
  import bps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  input  logic [SZ_W-1:0]   bits,
  output logic [MAXB_W-1:0] byte_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (load)    sr_q <= load_word;
    else if (advance) sr_q <= sr_q << bits;
  end

  // The current byte always sits at the top of the shift register.
  assign byte_o = sr_q[WORD_W-1 -: MAXB_W] >> (SZ_W'(MAXB_W) - bits);
endmodule

// File: rtl/bps_pack.sv
module bps_pack
  import bps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              insert,
  input  logic [POS_W-1:0]  pos,
  input  logic [SZ_W-1:0]   bits,
  input  logic [MAXB_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q;
  logic [MAXB_W-1:0] masked;
  logic [WORD_W-1:0] placed;
  logic [5:0]        shamt;
  int                used;

  always_comb begin
    masked = byte_i & ({MAXB_W{1'b1}} >> (SZ_W'(MAXB_W) - bits));
    used   = int'(bits) * (int'(pos) + 1);
    shamt  = 6'(WORD_W - used);
    placed = {{(WORD_W-MAXB_W){1'b0}}, masked} << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (insert)  acc_q <= acc_q | placed;
  end

  assign word_o = acc_q;
endmodule

// File: rtl/bps_seq.sv
module bps_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir,
  input  logic [2:0]        size_code,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              wc_ovf,
  output logic              size_err,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [15:0]       rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [15:0]       wr_data,
  input  logic              wr_last,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [35:0]       mem_wdata,
  input  logic [35:0]       mem_rdata
);
  bps_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [POS_W-1:0]  pos_q;
  logic [SZ_W-1:0]   bits_q;
  logic [POS_W-1:0]  per_word_q;
  logic              ovf_q, err_q, last_q;
  bps_fmt_t          fmt_in;

  logic take_start, rd_fire, wr_fire, word_end_rd, count_done;

  bps_size_decode u_dec (.code(size_code), .fmt(fmt_in));

  assign take_start  = start && (state_q == ST_IDLE);
  assign rd_fire     = (state_q == ST_RSTREAM) && rd_ready;
  assign wr_fire     = (state_q == ST_WFILL) && wr_valid;
  assign word_end_rd = (pos_q == per_word_q - 3'd1);
  assign count_done  = (cnt_q == CNT_W'(1));

  bps_unpack u_unpack (
    .clk(clk), .rst(rst),
    .load(state_q == ST_RWAIT), .load_word(mem_rdata),
    .advance(rd_fire), .bits(bits_q), .byte_o(rd_data)
  );

  bps_pack u_pack (
    .clk(clk), .rst(rst),
    .clear(state_q == ST_WWRITE || take_start), .insert(wr_fire),
    .pos(pos_q), .bits(bits_q), .byte_i(wr_data), .word_o(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      cnt_q      <= '0;
      pos_q      <= '0;
      bits_q     <= '0;
      per_word_q <= '0;
      ovf_q      <= 1'b0;
      err_q      <= 1'b0;
      last_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (take_start) begin
          ovf_q  <= 1'b0;
          err_q  <= 1'b0;
          last_q <= 1'b0;
          pos_q  <= '0;
          if (!fmt_in.legal) begin
            err_q <= 1'b1;
          end else if (word_count == '0) begin
            ovf_q <= 1'b1;
          end else begin
            addr_q     <= base_addr;
            cnt_q      <= word_count;
            bits_q     <= fmt_in.bits;
            per_word_q <= fmt_in.per_word;
            state_q    <= dir ? ST_WFILL : ST_RREQ;
          end
        end
        ST_RREQ:  state_q <= ST_RWAIT;
        ST_RWAIT: state_q <= ST_RSTREAM;
        ST_RSTREAM: if (rd_fire) begin
          if (word_end_rd) begin
            pos_q  <= '0;
            addr_q <= addr_q + ADDR_W'(1);
            cnt_q  <= cnt_q - CNT_W'(1);
            if (count_done) begin
              ovf_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RREQ;
            end
          end else begin
            pos_q <= pos_q + 3'd1;
          end
        end
        ST_WFILL: if (wr_fire) begin
          if (word_end_rd || wr_last) begin
            last_q  <= wr_last;
            state_q <= ST_WWRITE;
          end else begin
            pos_q <= pos_q + 3'd1;
          end
        end
        ST_WWRITE: begin
          pos_q  <= '0;
          addr_q <= addr_q + ADDR_W'(1);
          cnt_q  <= cnt_q - CNT_W'(1);
          if (count_done) begin
            ovf_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (last_q) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_WFILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign wc_ovf   = ovf_q;
  assign size_err = err_q;
  assign rd_valid = (state_q == ST_RSTREAM);
  assign wr_ready = (state_q == ST_WFILL);
  assign mem_req  = (state_q == ST_RREQ) || (state_q == ST_WWRITE);
  assign mem_we   = (state_q == ST_WWRITE);
  assign mem_addr = addr_q;

  // R8: a stalled byte holds its value
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)))
    else $error("a_r8_hold");

  // R5: an illegal size never reaches memory
  a_r5_no_access: assert property (@(posedge clk) disable iff (rst)
    size_err |-> !mem_req)
    else $error("a_r5_no_access");

  // R4: no access once the count is spent
  a_r4_count_live: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (cnt_q != '0))
    else $error("a_r4_count_live");

  // R4: overflow flag only while stopped
  a_r4_stopped: assert property (@(posedge clk) disable iff (rst)
    wc_ovf |-> !busy)
    else $error("a_r4_stopped");

  // R10: a start while busy leaves the byte size alone
  a_r10_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(bits_q))
    else $error("a_r10_ignore");
endmodule

// File: tb/bps_seq_tb.sv
module bps_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int CNT_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, dir = 1'b0;
  logic [2:0] size_code = '0;
  logic [CNT_W-1:0] word_count = '0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic busy, wc_ovf, size_err, rd_valid, wr_ready, mem_req, mem_we;
  logic rd_ready = 1'b0, wr_valid = 1'b0, wr_last = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] wr_data = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic [35:0] mem_wdata;
  logic [35:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bps_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .size_code(size_code),
    .word_count(word_count), .base_addr(base_addr), .busy(busy),
    .wc_ovf(wc_ovf), .size_err(size_err), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model and access log
  logic [35:0] mem [64];
  logic [5:0]  rlog [64];
  logic [5:0]  wlog [64];
  int rlog_n = 0, wlog_n = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      mem_rdata <= mem[mem_addr[5:0]];
      if (rlog_n < 64) rlog[rlog_n] = mem_addr[5:0];
      rlog_n = rlog_n + 1;
    end
    if (mem_req && mem_we) begin
      mem[mem_addr[5:0]] <= mem_wdata;
      if (wlog_n < 64) wlog[wlog_n] = mem_addr[5:0];
      wlog_n = wlog_n + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_bits(input logic [2:0] code);
    case (code)
      3'd2: return 16;
      3'd3: return 12;
      3'd4: return 8;
      3'd5: return 7;
      3'd6: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] field_of(input logic [35:0] w, input int s, input int k);
    logic [35:0] t;
    t = w >> (36 - s * (k + 1));
    return 16'(t & ((36'd1 << s) - 36'd1));
  endfunction

  task automatic clr_logs();
    rlog_n = 0;
    wlog_n = 0;
  endtask

  task automatic pulse_start(input logic d, input logic [2:0] c, input int n, input int a);
    @(negedge clk);
    start = 1'b1; dir = d; size_code = c;
    word_count = CNT_W'(n); base_addr = ADDR_W'(a);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Read transfer with a ready pattern; optional start injected while busy
  task automatic do_read(input logic [2:0] code, input int n, input int a,
                         input logic [7:0] pat, input bit inject);
    int s, bpw, got, total;
    bit pv, pr;
    logic [15:0] pd;
    s = exp_bits(code); bpw = 36 / s; total = bpw * n; got = 0;
    pv = 1'b0; pr = 1'b0; pd = '0;
    clr_logs();
    @(negedge clk);
    start = 1'b1; dir = 1'b0; size_code = code;
    word_count = CNT_W'(n); base_addr = ADDR_W'(a);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (inject && i == 4) begin
        start = 1'b1; dir = 1'b1; size_code = 3'd2; base_addr = ADDR_W'(33);
      end
      if (inject && i == 5) start = 1'b0;
      if (!busy) break;
      if (pv && !pr) chk(rd_valid && rd_data == pd, "R8 stalled byte held", {19'd0, rd_valid, rd_data}, {20'd1, pd});
      rd_ready = pat[i % 8];
      if (rd_valid && rd_ready) begin
        if (got < total)
          chk(rd_data == field_of(mem[6'((a + got / bpw) % 64)], s, got % bpw),
              "R2 read byte", {20'd0, rd_data},
              {20'd0, field_of(mem[6'((a + got / bpw) % 64)], s, got % bpw)});
        got++;
      end
      pv = rd_valid; pr = rd_ready; pd = rd_data;
    end
    rd_ready = 1'b0;
    chk(got == total, "R1 byte count per transfer", 36'(got), 36'(total));
    chk(wc_ovf == 1'b1 && !busy, "R4 overflow at end", {35'd0, wc_ovf}, 36'd1);
    chk(size_err == 1'b0, "R5 no error on legal size", {35'd0, size_err}, 36'd0);
    chk(rlog_n == n, "R3 one access per word", 36'(rlog_n), 36'(n));
    for (int w = 0; w < n && w < 64; w++)
      chk(rlog[w] == 6'((a + w) % 64), "R3 read address", {30'd0, rlog[w]}, 36'((a + w) % 64));
  endtask

  // Write transfer of nb bytes; ovf_exp gives the expected flag
  task automatic do_write(input logic [2:0] code, input int n, input int a,
                          input int nb, input bit use_last, input bit ovf_exp);
    int s, bpw, k, wi, wp, nw;
    logic [35:0] expw [8];
    logic [15:0] b;
    s = exp_bits(code); bpw = 36 / s;
    wi = 0; wp = 0;
    for (int j = 0; j < 8; j++) expw[j] = '0;
    for (int j = 0; j < nb; j++) begin
      b = 16'hF000 ^ 16'(j * 16'h1357) ^ 16'h0A5A;
      expw[wi] = expw[wi] | ((36'(b) & ((36'd1 << s) - 36'd1)) << (36 - s * (wp + 1)));
      wp++;
      if (wp == bpw) begin wp = 0; wi++; end
    end
    nw = (wp == 0) ? wi : wi + 1;
    clr_logs();
    pulse_start(1'b1, code, n, a);
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      if (!busy) break;
      if (k < nb) begin
        b = 16'hF000 ^ 16'(k * 16'h1357) ^ 16'h0A5A;
        wr_valid = 1'b1; wr_data = b; wr_last = use_last && (k == nb - 1);
        if (wr_ready) k++;
      end else begin
        wr_valid = 1'b0; wr_last = 1'b0;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_last = 1'b0;
    @(negedge clk);
    chk(wlog_n == nw, "R3 one write per word", 36'(wlog_n), 36'(nw));
    for (int w = 0; w < nw; w++) begin
      chk(mem[6'((a + w) % 64)] == expw[w], use_last ? "R7 packed word" : "R6 packed word",
          mem[6'((a + w) % 64)], expw[w]);
      chk(wlog[w] == 6'((a + w) % 64), "R3 write address", {30'd0, wlog[w]}, 36'((a + w) % 64));
    end
    chk(wc_ovf == ovf_exp, "R7 overflow flag after write", {35'd0, wc_ovf}, {35'd0, ovf_exp});
  endtask

  // code[20:18] count[17:14] addr[13:8] ready pattern[7:0]
  localparam logic [20:0] VEC [8] = '{
    {3'd2, 4'd3, 6'd0,  8'hFF},
    {3'd3, 4'd2, 6'd5,  8'hAA},
    {3'd4, 4'd2, 6'd10, 8'hFF},
    {3'd5, 4'd2, 6'd20, 8'hB6},
    {3'd6, 4'd2, 6'd30, 8'hDD},
    {3'd6, 4'd1, 6'd40, 8'h0F},
    {3'd4, 4'd4, 6'd44, 8'hE7},
    {3'd2, 4'd1, 6'd50, 8'h33}
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++)
      mem[i] = 36'((64'h9E3779B97F4A7C15 * 64'(i + 3)) >> 7);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!busy && !wc_ovf && !size_err, "R9 status after reset",
        {33'd0, busy, wc_ovf, size_err}, 36'd0);
    chk(!mem_req && !rd_valid && !wr_ready, "R9 handshakes after reset",
        {33'd0, mem_req, rd_valid, wr_ready}, 36'd0);

    // Table of read vectors (R1 R2 R3 R4 R8)
    for (int v = 0; v < 8; v++)
      do_read(VEC[v][20:18], int'(VEC[v][17:14]), int'(VEC[v][13:8]), VEC[v][7:0], 1'b0);

    // R5: illegal size codes
    for (int c = 0; c < 3; c++) begin
      clr_logs();
      pulse_start(1'b0, (c == 0) ? 3'd0 : (c == 1) ? 3'd1 : 3'd7, 2, 12);
      chk(size_err && !busy && !rd_valid, "R5 illegal code flagged",
          {33'd0, size_err, busy, rd_valid}, 36'd4);
      repeat (4) @(negedge clk);
      chk(rlog_n == 0 && wlog_n == 0 && !rd_valid, "R5 no access on illegal code",
          36'(rlog_n + wlog_n), 36'd0);
    end

    // R4: zero count
    clr_logs();
    pulse_start(1'b0, 3'd4, 0, 3);
    chk(wc_ovf && !busy && !size_err, "R4 zero count overflows at once",
        {33'd0, wc_ovf, busy, size_err}, 36'd4);
    repeat (4) @(negedge clk);
    chk(rlog_n == 0, "R4 zero count makes no access", 36'(rlog_n), 36'd0);

    // R6: full-word writes, 8-bit and 16-bit
    do_write(3'd4, 2, 16, 8, 1'b0, 1'b1);
    do_write(3'd2, 3, 24, 6, 1'b0, 1'b1);
    do_write(3'd6, 1, 62, 6, 1'b1, 1'b1);

    // R7: early end with a partial word
    mem[61] = 36'h123456789;
    do_write(3'd5, 3, 60, 2, 1'b1, 1'b0);
    chk(mem[61] == 36'h123456789, "R7 next word untouched", mem[61], 36'h123456789);
    do_write(3'd3, 3, 56, 4, 1'b1, 1'b0);

    // R10: start while busy is ignored
    do_read(3'd4, 1, 7, 8'hF0, 1'b1);
    chk(wlog_n == 0, "R10 injected start made no write", 36'(wlog_n), 36'd0);

    // R2: read back a written word to check its left-justified layout
    do_read(3'd3, 2, 56, 8'hFF, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule